// File: doc/BRIEF.md
# Serial Program/Verify Port Target

This block is the device-side end of a two-wire programming link. An external programmer toggles a serial clock pin and moves bits over one bidirectional data pin. The block samples both pins with the fast system clock through synchronizers and finds the serial clock edges in the system clock domain. It assembles 6-bit commands and, for the load and read commands, a 16-cycle data frame that carries a 14-bit word.

The block keeps a 14-bit address counter and presents it on a simple memory port. That port has an address, a write word, a one-cycle write strobe and a read word. The programmer loads a word and then triggers a write. It reads the word back to verify it, and then steps the counter to the next address. A load-configuration command moves the counter into the configuration region at 0x2000. The block stays in that region until the next reset, which stands for leaving the programming mode.

Top module: `sprog_target`

## Requirements
- R1: While `rst` is high and in the cycle after it falls: `mem_addr`=0, `mem_we`=0, `sdat_oe`=0, `sdat_out`=0 and `cfg_mode`=0.
- R2: A command is the data-pin value at 6 consecutive serial clock falling edges, least significant bit first. The codes are: load configuration 6'b000000, load data 6'b000010, read data 6'b000100, increment address 6'b000110, begin programming 6'b001000.
- R3: A load-data frame lasts 16 serial clock cycles. The data-pin values at the falling edges of cycles 2 to 15 form the 14-bit word, least significant bit first. The values in cycle 1 and cycle 16 are ignored.
- R4: Increment address adds one to `mem_addr`. The change appears within 6 system clocks after the sixth falling edge of the command.
- R5: Begin programming produces one `mem_we` pulse, one system clock long. During the pulse, `mem_addr` holds the counter and `mem_wdata` holds the most recently loaded word. Repeating the command writes the same word again.
- R6: A read frame lasts 16 serial clock cycles. It sends the `mem_rdata` word for the current address, least significant bit first, on the rising edges of cycles 2 to 15. `sdat_out` is 0 in cycles 1 and 16. `sdat_oe` is high from the rising edge of cycle 1 until the falling edge of cycle 16. Whenever `sdat_oe` is low, `sdat_out` is 0.
- R7: A code that is not assigned changes neither the address nor `mem_wdata`, gives no write strobe and starts no data frame, so the next 6 clock cycles are taken as a new command.
- R8: Load configuration sets `mem_addr` to 0x2000 and raises `cfg_mode`. A data frame follows it, and that frame loads the word in the same way as load data.
- R9: Once `cfg_mode` is high, only `rst` clears it. While it is high, bit 13 of `mem_addr` stays set, so an increment from 0x3FFF wraps to 0x2000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; also marks mode exit |
| sclk_pin | input | 1 | Serial clock pin, asynchronous |
| sdat_pin | input | 1 | Serial data pin input value, asynchronous |
| sdat_out | output | 1 | Value driven onto the data pin |
| sdat_oe | output | 1 | Output enable for the data pin |
| mem_addr | output | 14 | Address counter to the memory |
| mem_wdata | output | 14 | Last loaded word |
| mem_we | output | 1 | One-cycle write strobe |
| mem_rdata | input | 14 | Read word for `mem_addr` |
| cfg_mode | output | 1 | Configuration region entered |

## Verification
The bench sends load frames whose start and stop slots are driven to 1. A design that took a payload bit from the wrong falling edge would store a shifted word. The bench reads words with alternating bit patterns and checks the start and stop slots. A read shifter that is off by one slot, or an enable that drops early, gives a wrong word back or leaves the pin undriven. An unassigned code is followed at once by a valid command, so a design that expected a data frame after the bad code would lose that command. After load configuration, the bench sends increments and load data and then resets. This shows that the counter stays in the configuration region, and only reset brings it back to 0.

// File: rtl/sprog_pkg.sv
package sprog_pkg;
  localparam int CMD_W = 6;
  localparam int WORD_W = 14;
  localparam int FRAME_LEN = 16;

  localparam logic [CMD_W-1:0] OP_LOAD_CFG  = 6'b000000;
  localparam logic [CMD_W-1:0] OP_LOAD_DATA = 6'b000010;
  localparam logic [CMD_W-1:0] OP_READ_DATA = 6'b000100;
  localparam logic [CMD_W-1:0] OP_INC_ADDR  = 6'b000110;
  localparam logic [CMD_W-1:0] OP_PROGRAM   = 6'b001000;

  typedef enum logic [1:0] {
    ST_CMD,
    ST_LOAD,
    ST_READ
  } link_state_t;
endpackage

// File: rtl/sprog_sync.sv
module sprog_sync #(
  parameter int N = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], din[i]};
    end
    assign dout[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/sprog_addr.sv
module sprog_addr #(
  parameter int AW = 14,
  parameter logic [AW-1:0] CFG_BASE = 14'h2000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          jump_cfg,
  output logic [AW-1:0] addr,
  output logic          cfg
);
  logic [AW-1:0] stepped;
  assign stepped = addr + AW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
      cfg  <= 1'b0;
    end else if (jump_cfg) begin
      addr <= CFG_BASE;
      cfg  <= 1'b1;
    end else if (inc) begin
      addr <= cfg ? (stepped | CFG_BASE) : stepped;
    end
  end
endmodule

// File: rtl/sprog_link.sv
module sprog_link
  import sprog_pkg::*;
#(
  parameter int CW = CMD_W,
  parameter int DW = WORD_W,
  parameter int FL = FRAME_LEN
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sclk_s,
  input  logic          sdat_s,
  input  logic [DW-1:0] rd_word,
  output logic          ev_cfg,
  output logic          ev_inc,
  output logic          ev_prog,
  output logic          word_valid,
  output logic [DW-1:0] word,
  output logic          tx_bit,
  output logic          tx_en
);
  localparam int NW = $clog2(FL);
  localparam logic [NW-1:0] CMD_LAST   = NW'(CW - 1);
  localparam logic [NW-1:0] FRAME_LAST = NW'(FL - 1);
  localparam logic [NW-1:0] PAY_LAST   = NW'(DW);

  link_state_t   st;
  logic [NW-1:0] cnt;
  logic [CW-1:0] csr;
  logic [CW-1:0] cmd_next;
  logic [DW-1:0] osr;
  logic          sclk_q;
  logic          rise, fall;

  assign rise     = sclk_s & ~sclk_q;
  assign fall     = ~sclk_s & sclk_q;
  assign cmd_next = {sdat_s, csr[CW-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_CMD;
      cnt <= '0;
      csr <= '0;
      osr <= '0;
      word <= '0;
      sclk_q <= 1'b0;
      tx_bit <= 1'b0;
      tx_en <= 1'b0;
      ev_cfg <= 1'b0;
      ev_inc <= 1'b0;
      ev_prog <= 1'b0;
      word_valid <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      ev_cfg <= 1'b0;
      ev_inc <= 1'b0;
      ev_prog <= 1'b0;
      word_valid <= 1'b0;
      case (st)
        ST_CMD: begin
          if (fall) begin
            csr <= cmd_next;
            if (cnt == CMD_LAST) begin
              cnt <= '0;
              case (cmd_next)
                OP_LOAD_CFG: begin
                  ev_cfg <= 1'b1;
                  st <= ST_LOAD;
                end
                OP_LOAD_DATA: st <= ST_LOAD;
                OP_READ_DATA: st <= ST_READ;
                OP_INC_ADDR:  ev_inc <= 1'b1;
                OP_PROGRAM:   ev_prog <= 1'b1;
                default: ;
              endcase
            end else begin
              cnt <= cnt + NW'(1);
            end
          end
        end
        ST_LOAD: begin
          if (fall) begin
            if (cnt != '0 && cnt <= PAY_LAST)
              word <= {sdat_s, word[DW-1:1]};
            if (cnt == FRAME_LAST) begin
              word_valid <= 1'b1;
              cnt <= '0;
              st <= ST_CMD;
            end else begin
              cnt <= cnt + NW'(1);
            end
          end
        end
        ST_READ: begin
          if (rise) begin
            if (cnt == '0) begin
              tx_en <= 1'b1;
              tx_bit <= 1'b0;
              osr <= rd_word;
            end else if (cnt <= PAY_LAST) begin
              tx_bit <= osr[0];
              osr <= osr >> 1;
            end else begin
              tx_bit <= 1'b0;
            end
          end
          if (fall) begin
            if (cnt == FRAME_LAST) begin
              tx_en <= 1'b0;
              tx_bit <= 1'b0;
              cnt <= '0;
              st <= ST_CMD;
            end else begin
              cnt <= cnt + NW'(1);
            end
          end
        end
        default: st <= ST_CMD;
      endcase
    end
  end
endmodule

// File: rtl/sprog_target.sv
module sprog_target
  import sprog_pkg::*;
#(
  parameter int AW = 14,
  parameter int DW = WORD_W,
  parameter int SYNC_STAGES = 2,
  parameter logic [AW-1:0] CFG_BASE = 14'h2000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sclk_pin,
  input  logic          sdat_pin,
  output logic          sdat_out,
  output logic          sdat_oe,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata,
  output logic          cfg_mode
);
  logic [1:0]    pins_s;
  logic          ev_cfg, ev_inc, ev_prog, word_valid;
  logic [DW-1:0] word;

  sprog_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .din({sdat_pin, sclk_pin}),
    .dout(pins_s)
  );

  sprog_link #(.CW(CMD_W), .DW(DW), .FL(FRAME_LEN)) u_link (
    .clk(clk), .rst(rst),
    .sclk_s(pins_s[0]), .sdat_s(pins_s[1]),
    .rd_word(mem_rdata),
    .ev_cfg(ev_cfg), .ev_inc(ev_inc), .ev_prog(ev_prog),
    .word_valid(word_valid), .word(word),
    .tx_bit(sdat_out), .tx_en(sdat_oe)
  );

  sprog_addr #(.AW(AW), .CFG_BASE(CFG_BASE)) u_addr (
    .clk(clk), .rst(rst),
    .inc(ev_inc), .jump_cfg(ev_cfg),
    .addr(mem_addr), .cfg(cfg_mode)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we <= 1'b0;
      mem_wdata <= '0;
    end else begin
      mem_we <= ev_prog;
      if (word_valid) mem_wdata <= word;
    end
  end
endmodule

// File: rtl/sprog_target_chk.sv
module sprog_target_chk #(
  parameter int AW = 14,
  parameter int DW = 14
) (
  input logic          clk,
  input logic          rst,
  input logic          sdat_out,
  input logic          sdat_oe,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_we,
  input logic          cfg_mode
);
  assert_we_single_R5: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  assert_pin_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !sdat_oe |-> !sdat_out);

  assert_cfg_jump_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_mode) |-> (mem_addr == 14'h2000));

  assert_cfg_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    cfg_mode |=> cfg_mode);

  assert_cfg_region_R9: assert property (@(posedge clk) disable iff (rst)
    cfg_mode |-> mem_addr[AW-1]);

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(mem_addr) |-> (mem_addr == $past(mem_addr) + AW'(1)) || (mem_addr == 14'h2000));

  assert_wdata_hold_R5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $stable(mem_wdata));
endmodule

bind sprog_target sprog_target_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .sdat_out(sdat_out), .sdat_oe(sdat_oe),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
  .cfg_mode(cfg_mode)
);

// File: tb/sim_sprog_target.sv
`timescale 1ns/1ps
module sim_sprog_target;
  localparam int PH = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk_pin = 1'b0;
  logic sdat_pin = 1'b0;
  logic sdat_out, sdat_oe, mem_we, cfg_mode;
  logic [13:0] mem_addr, mem_wdata, mem_rdata;

  logic [13:0] bmem [0:31];
  int we_cnt = 0;
  logic [13:0] we_addr, we_data;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sprog_target u0 (
    .clk(clk), .rst(rst), .sclk_pin(sclk_pin), .sdat_pin(sdat_pin),
    .sdat_out(sdat_out), .sdat_oe(sdat_oe), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata),
    .cfg_mode(cfg_mode)
  );

  function automatic int idx(logic [13:0] a);
    return int'({a[13], a[3:0]});
  endfunction

  assign mem_rdata = bmem[idx(mem_addr)];

  always @(posedge clk) begin
    if (mem_we) begin
      we_cnt <= we_cnt + 1;
      we_addr <= mem_addr;
      we_data <= mem_wdata;
      bmem[idx(mem_addr)] <= mem_wdata;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input logic b);
    @(negedge clk);
    sdat_pin = b;
    sclk_pin = 1'b1;
    wait_clk(PH);
    sclk_pin = 1'b0;
    wait_clk(PH);
  endtask

  task automatic send_cmd(input logic [5:0] c);
    for (int i = 0; i < 6; i++) sbit(c[i]);
    wait_clk(6);
  endtask

  task automatic load_frame(input logic [13:0] w);
    sbit(1'b1);
    for (int i = 0; i < 14; i++) sbit(w[i]);
    sbit(1'b1);
    wait_clk(6);
  endtask

  task automatic read_frame(input string req, input logic [13:0] exp);
    logic [13:0] got;
    logic oe_ok, start_v, stop_v;
    got = '0;
    oe_ok = 1'b1;
    start_v = 1'b1;
    stop_v = 1'b1;
    sdat_pin = 1'b0;
    for (int s = 0; s < 16; s++) begin
      @(negedge clk);
      sclk_pin = 1'b1;
      wait_clk(PH);
      if (!sdat_oe) oe_ok = 1'b0;
      if (s == 0) start_v = sdat_out;
      else if (s == 15) stop_v = sdat_out;
      else got[s-1] = sdat_out;
      sclk_pin = 1'b0;
      wait_clk(PH);
    end
    wait_clk(6);
    chk(got == exp, {req, " read word"}, int'(got), int'(exp));
    chk(oe_ok, {req, " oe held through frame"}, int'(oe_ok), 1);
    chk(!start_v && !stop_v, {req, " start/stop slots 0"}, int'({start_v, stop_v}), 0);
    chk(!sdat_oe, {req, " oe released after frame"}, int'(sdat_oe), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    wait_clk(3);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(mem_addr == 0 && !mem_we && !sdat_oe && !sdat_out && !cfg_mode, "R1 reset state",
        int'({cfg_mode, sdat_oe, sdat_out, mem_we, mem_addr}), 0);
  endtask

  task automatic t_load_prog();
    int n0;
    send_cmd(6'b000010);
    load_frame(14'h01A5);
    chk(mem_wdata == 14'h01A5, "R3 load word with start/stop=1", int'(mem_wdata), 'h1A5);
    n0 = we_cnt;
    send_cmd(6'b001000);
    chk(we_cnt == n0 + 1, "R5 one strobe", we_cnt - n0, 1);
    chk(we_addr == 0 && we_data == 14'h01A5, "R5 strobe addr/data",
        int'({we_addr, we_data}), 'h1A5);
    send_cmd(6'b001000);
    chk(we_cnt == n0 + 2 && we_data == 14'h01A5, "R5 repeat writes same word",
        int'(we_data), 'h1A5);
  endtask

  task automatic t_read();
    send_cmd(6'b000100);
    read_frame("R6 addr0", 14'h01A5);
  endtask

  task automatic t_inc_patterns();
    send_cmd(6'b000110);
    chk(mem_addr == 1, "R4 increment", int'(mem_addr), 1);
    send_cmd(6'b000010);
    load_frame(14'h3FFF);
    send_cmd(6'b001000);
    send_cmd(6'b000100);
    read_frame("R6 ones", 14'h3FFF);
    send_cmd(6'b000110);
    chk(mem_addr == 2, "R2 R4 second increment", int'(mem_addr), 2);
    send_cmd(6'b000010);
    load_frame(14'h2AAA);
    send_cmd(6'b001000);
    send_cmd(6'b000100);
    read_frame("R6 alternating", 14'h2AAA);
  endtask

  task automatic t_bad_code();
    int n0;
    n0 = we_cnt;
    send_cmd(6'b111111);
    chk(mem_addr == 2 && we_cnt == n0 && mem_wdata == 14'h2AAA, "R7 bad code no effect",
        int'(mem_addr), 2);
    send_cmd(6'b000110);
    chk(mem_addr == 3, "R7 next command decoded", int'(mem_addr), 3);
  endtask

  task automatic t_cfg();
    send_cmd(6'b000000);
    chk(mem_addr == 14'h2000 && cfg_mode, "R8 cfg jump", int'({cfg_mode, mem_addr}), 'h6000);
    load_frame(14'h1357);
    chk(mem_wdata == 14'h1357, "R8 cfg frame loads word", int'(mem_wdata), 'h1357);
    send_cmd(6'b001000);
    chk(we_addr == 14'h2000 && we_data == 14'h1357, "R8 cfg write", int'(we_addr), 'h2000);
    send_cmd(6'b000110);
    send_cmd(6'b000010);
    load_frame(14'h0001);
    chk(mem_addr == 14'h2001 && cfg_mode, "R9 stays in cfg region", int'(mem_addr), 'h2001);
    send_cmd(6'b000100);
    read_frame("R9 cfg read", 14'h0000);
    do_reset();
    chk(mem_addr == 0 && !cfg_mode, "R9 R1 reset exits cfg", int'({cfg_mode, mem_addr}), 0);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) bmem[i] = '0;
    wait_clk(4);
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_load_prog();
    t_read();
    t_inc_patterns();
    t_bad_code();
    t_cfg();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule